// File: doc/BRIEF.md
# Legacy Paravirtual Device Register Window

This block implements the common register header of a legacy paravirtual I/O device that sits behind an I/O-space BAR. A host bridge presents byte, word or dword accesses at byte offsets inside the window. The block decodes each access by its exact offset and updates or returns the matching register. The registers cover feature negotiation, queue selection with per-queue ring page numbers and sizes, queue notification, device status, the read-to-acknowledge interrupt status byte, and the message-interrupt vector registers. Any offset beyond the common header is rebased and passed on to a device-specific configuration port.

The device side raises queue and configuration events. Without message interrupts these set interrupt status bits and drive a level interrupt line. With message interrupts enabled, each event instead requests a message that carries the vector programmed for it. A queue notify write produces a one-cycle strobe carrying the queue index. A zero status or zero page-number write resets the device state and pulses a reset output.

Top module: `pvio_regwin`

## Requirements
- R1: The header is 24 bytes when `msix_en` is 1 and 20 bytes when it is 0. An access at or above the header length drives `dcfg_valid` in the same cycle, with `dcfg_addr` equal to the offset minus the header length. The read returns `dcfg_rdata` masked to the access width.
- R2: Access width encoding on `acc_size` is 0 for byte, 1 for word, and 2 or 3 for dword. Write data is masked to that width, and read data is returned masked to that width. Host features at offset 0 read as the HOST_FEATURES parameter, and writes to offset 0 are ignored.
- R3: Inside the header, only offsets 0, 4, 8, 12, 14, 16, 18, 19 (and 20, 22 with message interrupts) are decoded. Any other offset there reads as all ones and ignores writes. Offset 16 reads 0. Writes to offsets 12 and 19 are ignored.
- R4: A write to queue select (offset 14) is stored only when the value is below NUM_QUEUES; otherwise the old value is kept. Offsets 8, 12 and 22 act on the selected queue. The size of queue q comes from `qsize_flat[16q+:16]`.
- R5: A non-zero write to offset 8 stores the ring page number of the selected queue. A read of offset 8 returns that queue's stored page number.
- R6: A write of zero to offset 8, or a write whose low byte is zero to offset 18, resets the device state on the next edge. Device state means status, guest features, queue select, every page number, every vector (to 0xFFFF) and the interrupt status. `dev_reset` is high for the cycle after the write.
- R7: A write to status (offset 18) stores the low 8 bits of the data.
- R8: A guest-features write (offset 4) whose bit BAD_FEAT_BIT is set stores HOST_FEATURES AND FALLBACK_MASK when FALLBACK_EN is 1, and 0 otherwise. Any other write stores the value unchanged.
- R9: A write to the config vector (offset 20) or the selected queue's vector (offset 22) stores the value when it is below NUM_VECTORS, and 0xFFFF otherwise.
- R10: A queue event sets status bit 0 and a config event sets bit 1 of the interrupt status byte (offset 19). A read of offset 19 returns the byte and clears it. `intx` equals bit 0 when `msix_en` is 0 and is 0 when `msix_en` is 1.
- R11: With `msix_en` at 1, an event raises `msi_req` for one cycle on the next cycle. `msi_vec` is the event queue's vector, or the config vector. A queue event takes priority over a config event in the same cycle. No request is raised when that vector is 0xFFFF.
- R12: A write to offset 16 pulses `notify_stb` for one cycle on the next cycle, with `notify_qidx` equal to the low 16 bits of the masked data.
- R13: Writing status with bit 2 (driver ready) set while `bus_master` is 0 sets a sticky flag that only `rst_n` clears. While the flag is clear, a falling edge of `bus_master` clears status bit 2.
- R14: A read access returns its data on `rd_data`, with `rd_valid` high, in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msix_en | input | 1 | Message interrupts enabled |
| bus_master | input | 1 | Bus-master enable from the command register |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | 2 | Access width code |
| acc_addr | input | ADDR_W | Byte offset within the window |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| dcfg_valid | output | 1 | Device-specific config access |
| dcfg_write | output | 1 | Device-specific access is a write |
| dcfg_size | output | 2 | Device-specific access width |
| dcfg_addr | output | ADDR_W | Rebased device-specific offset |
| dcfg_wdata | output | 32 | Device-specific write data |
| dcfg_rdata | input | 32 | Device-specific read data |
| qsize_flat | input | NUM_QUEUES*16 | Size of every queue |
| evt_queue | input | 1 | Queue interrupt event |
| evt_qidx | input | $clog2(NUM_QUEUES) | Queue of the event |
| evt_config | input | 1 | Configuration change event |
| intx | output | 1 | Legacy level interrupt |
| msi_req | output | 1 | Message interrupt request |
| msi_vec | output | 16 | Vector of the request |
| notify_stb | output | 1 | Queue notify strobe |
| notify_qidx | output | 16 | Notified queue index |
| dev_reset | output | 1 | Device reset pulse |

## Verification
The assertions check several relations on every cycle: the level interrupt stays low under message interrupts and drops after an acknowledging read. The notify strobe tracks notify writes exactly. A zero page-number write always yields a reset pulse. Requested vectors are always allocatable. Read-valid timing holds, and pass-through rebasing holds. The bench scenarios show the stored values. These include the queue-select rejection sweep, the per-queue page numbers and sizes, and the vector fallback sweep. They also cover the bad-feature fallback, the full state after both kinds of device reset, the sticky bus-master flag, and the all-ones reads of unmapped offsets, none of which a single-cycle property can express.

// File: rtl/pvio_pkg.sv
// Shared constants, region codes and helpers for the paravirtual register window.
package pvio_pkg;
    localparam int OFF_HFEAT  = 0;
    localparam int OFF_GFEAT  = 4;
    localparam int OFF_PFN    = 8;
    localparam int OFF_QNUM   = 12;
    localparam int OFF_QSEL   = 14;
    localparam int OFF_NOTIFY = 16;
    localparam int OFF_STAT   = 18;
    localparam int OFF_ISR    = 19;
    localparam int OFF_CVEC   = 20;
    localparam int OFF_QVEC   = 22;
    localparam int HDR_PLAIN  = 20;
    localparam int HDR_MSG    = 24;
    localparam logic [15:0] NO_VEC = 16'hFFFF;
    localparam int ST_READY_BIT = 2;

    typedef enum logic [3:0] {
        RG_HFEAT, RG_GFEAT, RG_PFN, RG_QNUM, RG_QSEL, RG_NOTIFY,
        RG_STAT, RG_ISR, RG_CVEC, RG_QVEC, RG_NONE, RG_DEV
    } region_e;

    // Byte-lane mask for an access width code.
    function automatic logic [31:0] width_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    width_mask = 32'h0000_00FF;
            2'd1:    width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/pvio_decode.sv
// Offset decoder: maps a window offset to a register region or to the
// device-specific area. Assumes exact-offset dispatch regardless of width.
module pvio_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              msix_en,
    input  logic [ADDR_W-1:0] addr,
    output pvio_pkg::region_e region,
    output logic [ADDR_W-1:0] dev_addr
);
    import pvio_pkg::*;

    logic [ADDR_W-1:0] hdr_len;
    assign hdr_len = msix_en ? ADDR_W'(HDR_MSG) : ADDR_W'(HDR_PLAIN);

    // Classify the offset and rebase pass-through accesses.
    always_comb begin
        region   = RG_NONE;
        dev_addr = '0;
        if (addr >= hdr_len) begin
            region   = RG_DEV;
            dev_addr = addr - hdr_len;
        end else begin
            case (addr)
                ADDR_W'(OFF_HFEAT):  region = RG_HFEAT;
                ADDR_W'(OFF_GFEAT):  region = RG_GFEAT;
                ADDR_W'(OFF_PFN):    region = RG_PFN;
                ADDR_W'(OFF_QNUM):   region = RG_QNUM;
                ADDR_W'(OFF_QSEL):   region = RG_QSEL;
                ADDR_W'(OFF_NOTIFY): region = RG_NOTIFY;
                ADDR_W'(OFF_STAT):   region = RG_STAT;
                ADDR_W'(OFF_ISR):    region = RG_ISR;
                ADDR_W'(OFF_CVEC):   region = RG_CVEC;
                ADDR_W'(OFF_QVEC):   region = RG_QVEC;
                default:             region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pvio_queue_bank.sv
// Per-queue state: ring page number and message vector for each queue.
// Assumes the write value for vectors is already validated by the caller.
module pvio_queue_bank #(
    parameter int NQ     = 4,
    parameter int QIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [QIDX_W-1:0] sel,
    input  logic              pfn_we,
    input  logic [31:0]       pfn_wdata,
    input  logic              vec_we,
    input  logic [15:0]       vec_wdata,
    input  logic [QIDX_W-1:0] evt_idx,
    output logic [31:0]       pfn_rd,
    output logic [15:0]       vec_rd,
    output logic [15:0]       evt_vec
);
    import pvio_pkg::*;

    logic [31:0] pfn_r [NQ];
    logic [15:0] vec_r [NQ];
    logic [NQ-1:0] pfn_hit, vec_hit;

    // One write-enable per queue from the selector.
    for (genvar q = 0; q < NQ; q++) begin : g_hit
        assign pfn_hit[q] = pfn_we && (sel == QIDX_W'(q));
        assign vec_hit[q] = vec_we && (sel == QIDX_W'(q));
    end

    // Hold page numbers and vectors; device reset restores defaults.
    always_ff @(posedge clk) begin
        for (int q = 0; q < NQ; q++) begin
            if (!rst_n || clr) begin
                pfn_r[q] <= '0;
                vec_r[q] <= NO_VEC;
            end else begin
                if (pfn_hit[q]) pfn_r[q] <= pfn_wdata;
                if (vec_hit[q]) vec_r[q] <= vec_wdata;
            end
        end
    end

    assign pfn_rd  = pfn_r[sel];
    assign vec_rd  = vec_r[sel];
    assign evt_vec = vec_r[evt_idx];
endmodule

// File: rtl/pvio_irq.sv
// Interrupt status byte, legacy level line and message request generation.
// Assumes an acknowledging read in the same cycle as an event loses to it.
module pvio_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        msix_en,
    input  logic        evt_queue,
    input  logic        evt_config,
    input  logic [15:0] q_vec,
    input  logic [15:0] cfg_vec,
    input  logic        isr_rd,
    output logic [7:0]  isr,
    output logic        intx,
    output logic        msi_req,
    output logic [15:0] msi_vec
);
    import pvio_pkg::*;

    logic [15:0] pick_vec;
    assign pick_vec = evt_queue ? q_vec : cfg_vec;

    // Status bits: set by events, cleared by acknowledging read or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            isr <= '0;
        end else begin
            isr <= (isr_rd ? 8'h00 : isr) | {6'b0, evt_config, evt_queue};
        end
    end

    // Message request one cycle after an event with an allocated vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_req <= 1'b0;
            msi_vec <= NO_VEC;
        end else begin
            msi_req <= msix_en && (evt_queue || evt_config) && (pick_vec != NO_VEC);
            msi_vec <= pick_vec;
        end
    end

    assign intx = !msix_en && isr[0];
endmodule

// File: rtl/pvio_regwin.sv
// Common register window of a legacy paravirtual device. Decodes window
// accesses, holds the header registers, forwards device-specific accesses.
// Assumes one access per cycle and a combinational device-specific read.
module pvio_regwin #(
    parameter int          ADDR_W        = 8,
    parameter int          NUM_QUEUES    = 4,
    parameter int          NUM_VECTORS   = 3,
    parameter int          BAD_FEAT_BIT  = 30,
    parameter logic [31:0] HOST_FEATURES = 32'h5100_0031,
    parameter bit          FALLBACK_EN   = 1'b1,
    parameter logic [31:0] FALLBACK_MASK = 32'h0000_00F1,
    localparam int         QIDX_W        = $clog2(NUM_QUEUES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     msix_en,
    input  logic                     bus_master,
    input  logic                     acc_valid,
    input  logic                     acc_write,
    input  logic [1:0]               acc_size,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [31:0]              acc_wdata,
    output logic                     rd_valid,
    output logic [31:0]              rd_data,
    output logic                     dcfg_valid,
    output logic                     dcfg_write,
    output logic [1:0]               dcfg_size,
    output logic [ADDR_W-1:0]        dcfg_addr,
    output logic [31:0]              dcfg_wdata,
    input  logic [31:0]              dcfg_rdata,
    input  logic [NUM_QUEUES*16-1:0] qsize_flat,
    input  logic                     evt_queue,
    input  logic [QIDX_W-1:0]        evt_qidx,
    input  logic                     evt_config,
    output logic                     intx,
    output logic                     msi_req,
    output logic [15:0]              msi_vec,
    output logic                     notify_stb,
    output logic [15:0]              notify_qidx,
    output logic                     dev_reset
);
    import pvio_pkg::*;

    region_e     region;
    logic [31:0] wval, amask, rd_mux, gfeat, pfn_rd;
    logic [15:0] qsel, cfg_vec, vec_rd, evt_vec, vec_ok;
    logic [7:0]  status, isr;
    logic        wr, rd, dev_rst_req, quirk, bm_q, bm_fall, isr_rd;
    logic [QIDX_W-1:0] qidx;

    pvio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .msix_en(msix_en), .addr(acc_addr), .region(region), .dev_addr(dcfg_addr)
    );

    assign wr      = acc_valid && acc_write;
    assign rd      = acc_valid && !acc_write;
    assign amask   = width_mask(acc_size);
    assign wval    = acc_wdata & amask;
    assign qidx    = qsel[QIDX_W-1:0];
    assign isr_rd  = rd && (region == RG_ISR);
    assign vec_ok  = (wval[15:0] < 16'(NUM_VECTORS)) ? wval[15:0] : NO_VEC;
    assign bm_fall = bm_q && !bus_master;
    assign dev_rst_req = (wr && region == RG_PFN  && wval == 32'h0)
                      || (wr && region == RG_STAT && wval[7:0] == 8'h0);

    assign dcfg_valid = acc_valid && (region == RG_DEV);
    assign dcfg_write = acc_write;
    assign dcfg_size  = acc_size;
    assign dcfg_wdata = acc_wdata;

    pvio_queue_bank #(.NQ(NUM_QUEUES), .QIDX_W(QIDX_W)) u_qbank (
        .clk(clk), .rst_n(rst_n), .clr(dev_rst_req), .sel(qidx),
        .pfn_we(wr && region == RG_PFN && wval != 32'h0), .pfn_wdata(wval),
        .vec_we(wr && region == RG_QVEC), .vec_wdata(vec_ok),
        .evt_idx(evt_qidx), .pfn_rd(pfn_rd), .vec_rd(vec_rd), .evt_vec(evt_vec)
    );

    pvio_irq u_irq (
        .clk(clk), .rst_n(rst_n), .clr(dev_rst_req), .msix_en(msix_en),
        .evt_queue(evt_queue), .evt_config(evt_config), .q_vec(evt_vec),
        .cfg_vec(cfg_vec), .isr_rd(isr_rd), .isr(isr), .intx(intx),
        .msi_req(msi_req), .msi_vec(msi_vec)
    );

    // Feature, selector, vector and status registers with device reset.
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst_req) begin
            gfeat   <= '0;
            qsel    <= '0;
            cfg_vec <= NO_VEC;
            status  <= '0;
        end else begin
            if (wr && region == RG_GFEAT) begin
                if (wval[BAD_FEAT_BIT])
                    gfeat <= FALLBACK_EN ? (HOST_FEATURES & FALLBACK_MASK) : 32'h0;
                else
                    gfeat <= wval;
            end
            if (wr && region == RG_QSEL && wval[15:0] < 16'(NUM_QUEUES))
                qsel <= wval[15:0];
            if (wr && region == RG_CVEC)
                cfg_vec <= vec_ok;
            if (wr && region == RG_STAT)
                status <= wval[7:0];
            else if (bm_fall && !quirk)
                status[ST_READY_BIT] <= 1'b0;
        end
    end

    // Sticky bus-master quirk flag and bus-master edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quirk <= 1'b0;
            bm_q  <= 1'b0;
        end else begin
            bm_q <= bus_master;
            if (wr && region == RG_STAT && wval[ST_READY_BIT] && !bus_master)
                quirk <= 1'b1;
        end
    end

    // Read data selection for the current access.
    always_comb begin
        case (region)
            RG_HFEAT:  rd_mux = HOST_FEATURES;
            RG_GFEAT:  rd_mux = gfeat;
            RG_PFN:    rd_mux = pfn_rd;
            RG_QNUM:   rd_mux = {16'h0, qsize_flat[qidx*16 +: 16]};
            RG_QSEL:   rd_mux = {16'h0, qsel};
            RG_NOTIFY: rd_mux = 32'h0;
            RG_STAT:   rd_mux = {24'h0, status};
            RG_ISR:    rd_mux = {24'h0, isr};
            RG_CVEC:   rd_mux = {16'h0, cfg_vec};
            RG_QVEC:   rd_mux = {16'h0, vec_rd};
            RG_DEV:    rd_mux = dcfg_rdata;
            default:   rd_mux = 32'hFFFF_FFFF;
        endcase
    end

    // Registered read return, notify strobe and device reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            notify_stb  <= 1'b0;
            notify_qidx <= '0;
            dev_reset   <= 1'b0;
        end else begin
            rd_valid    <= rd;
            rd_data     <= rd ? (rd_mux & amask) : rd_data;
            notify_stb  <= wr && region == RG_NOTIFY;
            notify_qidx <= wval[15:0];
            dev_reset   <= dev_rst_req;
        end
    end
endmodule

// File: rtl/pvio_regwin_chk.sv
// Property checker for the register window, attached by bind.
module pvio_regwin_chk #(
    parameter int ADDR_W = 8,
    parameter int NVEC   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msix_en,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_size,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_wdata,
    input logic              rd_valid,
    input logic              dcfg_valid,
    input logic [ADDR_W-1:0] dcfg_addr,
    input logic              evt_queue,
    input logic              evt_config,
    input logic              intx,
    input logic              msi_req,
    input logic [15:0]       msi_vec,
    input logic              notify_stb,
    input logic              dev_reset,
    input logic [15:0]       cfg_vec
);
    import pvio_pkg::*;

    logic wr_notify, wr_pfn0, rd_isr, rd_any;
    assign wr_notify = acc_valid && acc_write && acc_addr == ADDR_W'(OFF_NOTIFY);
    assign wr_pfn0   = acc_valid && acc_write && acc_addr == ADDR_W'(OFF_PFN)
                    && (acc_wdata & width_mask(acc_size)) == 32'h0;
    assign rd_isr    = acc_valid && !acc_write && acc_addr == ADDR_W'(OFF_ISR);
    assign rd_any    = acc_valid && !acc_write;

    // R12
    notify_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_notify |=> notify_stb);
    // R12
    notify_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_notify |=> !notify_stb);
    // R6
    pfn_zero_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pfn0 |=> dev_reset);
    // R10
    intx_quiet_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msix_en |-> !intx);
    // R10
    isr_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_isr && !evt_queue && !evt_config) |=> !intx);
    // R11
    msi_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> msi_vec < 16'(NVEC));
    // R11
    msi_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> $past(msix_en));
    // R9
    cfg_vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_vec == NO_VEC) || (cfg_vec < 16'(NVEC)));
    // R14
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> rd_valid);
    // R14
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !rd_valid);
    // R1
    pass_rebase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !msix_en && acc_addr >= ADDR_W'(HDR_PLAIN))
        |-> (dcfg_valid && dcfg_addr == acc_addr - ADDR_W'(HDR_PLAIN)));
endmodule

bind pvio_regwin pvio_regwin_chk #(.ADDR_W(ADDR_W), .NVEC(NUM_VECTORS)) u_chk (
    .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_size(acc_size), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .dcfg_valid(dcfg_valid),
    .dcfg_addr(dcfg_addr), .evt_queue(evt_queue), .evt_config(evt_config),
    .intx(intx), .msi_req(msi_req), .msi_vec(msi_vec), .notify_stb(notify_stb),
    .dev_reset(dev_reset), .cfg_vec(cfg_vec)
);

// File: tb/sim_pvio_regwin.sv
// Self-checking bench: sweeps offsets, selectors, vectors and events.
module sim_pvio_regwin;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NQ = 4;
    localparam int NV = 3;
    localparam int QW = 2;
    localparam logic [31:0] HF = 32'h5100_0031;
    localparam logic [31:0] FBM = 32'h0000_00F1;

    logic clk = 1'b0, rst_n = 1'b0, msix_en = 1'b0, bus_master = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_size = 2'd2;
    logic [AW-1:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic rd_valid, dcfg_valid, dcfg_write, intx, msi_req, notify_stb, dev_reset;
    logic [31:0] rd_data, dcfg_wdata, dcfg_rdata;
    logic [1:0] dcfg_size;
    logic [AW-1:0] dcfg_addr;
    logic [NQ*16-1:0] qsize_flat;
    logic evt_queue = 1'b0, evt_config = 1'b0;
    logic [QW-1:0] evt_qidx = '0;
    logic [15:0] msi_vec, notify_qidx;
    int checks = 0, errs = 0;
    logic [31:0] rv;
    logic last_rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int q = 0; q < NQ; q++) qsize_flat[q*16 +: 16] = 16'(32 + q*8);
    assign dcfg_rdata = 32'hC0DE_0000 | 32'(dcfg_addr);

    pvio_regwin #(.ADDR_W(AW), .NUM_QUEUES(NQ), .NUM_VECTORS(NV), .BAD_FEAT_BIT(30),
        .HOST_FEATURES(HF), .FALLBACK_EN(1'b1), .FALLBACK_MASK(FBM)) u0 (
        .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .bus_master(bus_master),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .dcfg_valid(dcfg_valid), .dcfg_write(dcfg_write),
        .dcfg_size(dcfg_size), .dcfg_addr(dcfg_addr), .dcfg_wdata(dcfg_wdata),
        .dcfg_rdata(dcfg_rdata), .qsize_flat(qsize_flat), .evt_queue(evt_queue),
        .evt_qidx(evt_qidx), .evt_config(evt_config), .intx(intx),
        .msi_req(msi_req), .msi_vec(msi_vec), .notify_stb(notify_stb),
        .notify_qidx(notify_qidx), .dev_reset(dev_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = AW'(a); acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rdx(input int a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = AW'(a); acc_size = sz;
        @(negedge clk);
        acc_valid = 1'b0;
        d = rd_data; last_rv = rd_valid;
    endtask

    task automatic pulse(input logic q, input logic c, input int idx);
        @(negedge clk);
        evt_queue = q; evt_config = c; evt_qidx = QW'(idx);
        @(negedge clk);
        evt_queue = 1'b0; evt_config = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] exp_sel;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset intx", {31'b0, intx}, 0);
        chk("R12 reset notify", {31'b0, notify_stb}, 0);
        chk("R6 reset pulse", {31'b0, dev_reset}, 0);
        chk("R11 reset msi", {31'b0, msi_req}, 0);

        // R14 read timing, R7 reset status
        rdx(18, 0, rv); chk("R7 status reset", rv, 0);
        chk("R14 rd_valid", {31'b0, last_rv}, 1);

        // R2 host features width masking and read-only
        rdx(0, 2, rv); chk("R2 hf dword", rv, HF);
        rdx(0, 1, rv); chk("R2 hf word", rv, HF & 32'hFFFF);
        rdx(0, 0, rv); chk("R2 hf byte", rv, HF & 32'hFF);
        wr(0, 2, 32'h0); rdx(0, 2, rv); chk("R2 hf write ignored", rv, HF);

        // R3 unmapped header offsets
        for (int a = 0; a < 20; a++) begin
            if (a != 0 && a != 4 && a != 8 && a != 12 && a != 14 && a != 16
                && a != 18 && a != 19) begin
                rdx(a, 0, rv); chk("R3 unmapped byte", rv, 32'hFF);
            end
        end
        rdx(13, 2, rv); chk("R3 unmapped dword", rv, 32'hFFFF_FFFF);
        wr(13, 2, 32'h1234); rdx(13, 2, rv); chk("R3 unmapped write", rv, 32'hFFFF_FFFF);
        rdx(16, 1, rv); chk("R3 notify reads 0", rv, 0);
        wr(12, 1, 16'h7); rdx(12, 1, rv); chk("R3 qnum read-only", rv, 32);

        // R1 pass-through rebasing in both header lengths
        for (int k = 0; k < 4; k++) begin
            rdx(20 + k, 2, rv); chk("R1 rebase plain", rv, 32'hC0DE_0000 | k);
        end
        rdx(21, 1, rv); chk("R1 rebase word mask", rv, 32'h0001);
        msix_en = 1'b1;
        rdx(24, 2, rv); chk("R1 rebase msg", rv, 32'hC0DE_0000);
        rdx(30, 2, rv); chk("R1 rebase msg 6", rv, 32'hC0DE_0006);
        rdx(20, 1, rv); chk("R9 cfg vec reset", rv, 16'hFFFF);

        // R4 queue select sweep
        exp_sel = 0;
        for (int v = 0; v < 8; v++) begin
            wr(14, 1, 32'(v));
            if (v < NQ) exp_sel = 16'(v);
            rdx(14, 1, rv); chk("R4 qsel", rv, {16'h0, exp_sel});
        end
        wr(14, 1, 32'h1_0002); rdx(14, 1, rv); chk("R4 qsel word mask", rv, 2);

        // R5 per-queue page numbers, R4 per-queue size
        for (int q = 0; q < NQ; q++) begin
            wr(14, 1, 32'(q)); wr(8, 2, 32'h0004_0100 + 32'(q));
        end
        for (int q = 0; q < NQ; q++) begin
            wr(14, 1, 32'(q));
            rdx(8, 2, rv); chk("R5 pfn", rv, 32'h0004_0100 + 32'(q));
            rdx(12, 1, rv); chk("R4 qsize", rv, 32'(32 + q*8));
        end

        // R9 vector validation sweep
        for (int v = 0; v < 6; v++) begin
            wr(20, 1, 32'(v)); rdx(20, 1, rv);
            chk("R9 cfg vec", rv, (v < NV) ? 32'(v) : 32'hFFFF);
        end
        wr(14, 1, 1);
        for (int v = 0; v < 6; v++) begin
            wr(22, 1, 32'(v)); rdx(22, 1, rv);
            chk("R9 queue vec", rv, (v < NV) ? 32'(v) : 32'hFFFF);
        end
        wr(14, 1, 0); rdx(22, 1, rv); chk("R9 other queue vec", rv, 32'hFFFF);

        // R8 guest features
        wr(4, 2, 32'h0000_0013); rdx(4, 2, rv); chk("R8 gf plain", rv, 32'h13);
        wr(4, 2, 32'h4000_0001); rdx(4, 2, rv); chk("R8 gf fallback", rv, HF & FBM);

        // R7 status low byte
        wr(18, 2, 32'h1234_56AB); rdx(18, 0, rv); chk("R7 status", rv, 32'hAB);

        // R12 notify strobe
        wr(16, 1, 32'h0003);
        chk("R12 notify strobe", {31'b0, notify_stb}, 1);
        chk("R12 notify index", {16'h0, notify_qidx}, 3);
        @(negedge clk); chk("R12 notify one cycle", {31'b0, notify_stb}, 0);

        // R10 interrupt status and level line
        msix_en = 1'b0;
        pulse(1, 0, 0); chk("R10 intx set", {31'b0, intx}, 1);
        rdx(19, 0, rv); chk("R10 isr read", rv, 1);
        chk("R10 intx cleared", {31'b0, intx}, 0);
        rdx(19, 0, rv); chk("R10 isr cleared", rv, 0);
        pulse(0, 1, 0); chk("R10 cfg no intx", {31'b0, intx}, 0);
        rdx(19, 0, rv); chk("R10 isr cfg", rv, 2);
        wr(19, 0, 8'h3); rdx(19, 0, rv); chk("R3 isr write ignored", rv, 0);
        msix_en = 1'b1;
        pulse(1, 0, 0); chk("R10 msg no intx", {31'b0, intx}, 0);
        rdx(19, 0, rv); chk("R10 isr under msg", rv, 1);

        // R11 message requests
        wr(14, 1, 2); wr(22, 1, 1); wr(20, 1, 2);
        pulse(1, 0, 2);
        chk("R11 msi queue req", {31'b0, msi_req}, 1);
        chk("R11 msi queue vec", {16'h0, msi_vec}, 1);
        @(negedge clk); chk("R11 msi one cycle", {31'b0, msi_req}, 0);
        pulse(1, 0, 3); chk("R11 no vector no req", {31'b0, msi_req}, 0);
        pulse(0, 1, 0);
        chk("R11 cfg req", {31'b0, msi_req}, 1);
        chk("R11 cfg vec", {16'h0, msi_vec}, 2);
        pulse(1, 1, 2); chk("R11 queue priority", {16'h0, msi_vec}, 1);

        // R13 bus-master quirk
        wr(18, 0, 8'h07);
        @(negedge clk); bus_master = 1'b0;
        repeat (2) @(negedge clk);
        rdx(18, 0, rv); chk("R13 ready cleared", rv, 32'h03);
        wr(18, 0, 8'h07);
        @(negedge clk); bus_master = 1'b1;
        repeat (2) @(negedge clk); bus_master = 1'b0;
        repeat (2) @(negedge clk);
        rdx(18, 0, rv); chk("R13 quirk keeps ready", rv, 32'h07);
        bus_master = 1'b1;

        // R6 device reset via zero page number
        wr(14, 1, 2); wr(4, 2, 32'h5);
        wr(8, 2, 32'h0);
        chk("R6 pfn reset pulse", {31'b0, dev_reset}, 1);
        rdx(18, 0, rv); chk("R6 status cleared", rv, 0);
        rdx(14, 1, rv); chk("R6 qsel cleared", rv, 0);
        rdx(4, 2, rv); chk("R6 gf cleared", rv, 0);
        rdx(20, 1, rv); chk("R6 cfg vec cleared", rv, 32'hFFFF);
        for (int q = 0; q < NQ; q++) begin
            wr(14, 1, 32'(q));
            rdx(8, 2, rv); chk("R6 pfn cleared", rv, 0);
            rdx(22, 1, rv); chk("R6 vec cleared", rv, 32'hFFFF);
        end
        // R6 device reset via zero status
        wr(14, 1, 1); wr(18, 0, 8'h01);
        wr(18, 2, 32'h0000_0100);
        chk("R6 status reset pulse", {31'b0, dev_reset}, 1);
        rdx(14, 1, rv); chk("R6 qsel after status", rv, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule